// File: doc/BRIEF.md
# Challenge-Response Authentication Sequencer

This block runs the master side of a token authentication exchange over a single-wire bus. It does not hash anything. It sits above a bit/byte bus engine and asks it for four kinds of operation: a bus reset with a presence sample, a byte write, a write-0 slot and a read slot. The byte values come from a small register file that holds a 64-bit challenge and the 160-bit response the token is expected to return. During the compute phase the block also drives an enable for a strong pull-up.

After a `start` pulse the block runs one attempt. It sends the challenge and asks the token to compute. It then reads back 160 response bits and compares each bit against the stored copy as the bit arrives. It closes the attempt with a final presence check. When the retry setting allows, a failing attempt is run again, and the first passing attempt ends the run early. A missing presence pulse at any reset ends the run at once with a "not present" result. Completion is signalled by a one-cycle `done` pulse and a result code.

Top module: `auth_seq`

## Requirements
- R1: While reset is held and just after it is released, `busy`, `done`, `ow_req` and `spu_en` are 0 and `result` is 0.
- R2: Each attempt begins with a reset (op 0) and then byte writes (op 1) of CCh and 0Ch, followed by the eight challenge bytes. The challenge bytes are read from register-file addresses 0 to 7 in ascending order.
- R3: Next come a second reset (op 0), a byte write of CCh, a byte write of 36h, the strong pull-up window and exactly eight write-0 slots (op 2).
- R4: After the write-0 slots the block issues exactly 160 read slots (op 3). Received bit k is compared with bit k%8 of register-file byte 8+k/8.
- R5: An attempt passes only when all 160 received bits equal the stored bits. A single differing bit at any position makes the attempt fail.
- R6: `spu_en` is high for exactly SPU_HOLD_CYCLES cycles after the 36h byte completes, and no request is issued in that time. The first write-0 request is raised in the cycle in which `spu_en` falls.
- R7: `retry_sel` (sampled at start) allows 1, 2, 4 or 8 attempts for the codes 00, 01, 10 and 11. The run stops at the first passing attempt.
- R8: If the final reset of an attempt sees no presence, the result is not-present, whatever the outcome of the compare.
- R9: If any reset sees no presence, the run ends at once with not-present and no further requests are made.
- R10: Completion is a single-cycle `done` pulse with `result` = 1 (not present), 2 (pass) or 3 (fail). `result` holds that value until the next completion.
- R11: A `start` pulse that arrives while `busy` is high has no effect on the running sequence or on its retry count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (ignored while busy) |
| retry_sel | input | 2 | Attempt-count code, sampled with start |
| ow_req | output | 1 | One-cycle request to the bus engine |
| ow_op | output | 2 | Requested operation: 0 reset, 1 write byte, 2 write-0, 3 read |
| ow_wdata | output | 8 | Byte to send for op 1 |
| ow_done | input | 1 | Engine finished the current request |
| ow_presence | input | 1 | Presence seen, valid with ow_done after op 0 |
| ow_rbit | input | 1 | Received bit, valid with ow_done after op 3 |
| rf_addr | output | 5 | Register-file byte address |
| rf_data | input | 8 | Register-file byte at rf_addr (combinational read) |
| spu_en | output | 1 | Strong pull-up enable |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | Completion code |

## Verification
The bench builds the block with SPU_HOLD_CYCLES set to 20. With the default of several million cycles, a single run would take longer than the whole run budget. The short window makes room for runs of eight attempts and for exact counting of the pull-up cycles in every attempt. A bus-engine model in the bench stands in for the token. It can corrupt a chosen response bit in a chosen number of leading attempts, or withhold presence at a chosen reset. This covers first-bit and last-bit mismatches, early pass, exhausted retries and a lost presence at every reset position.

// File: rtl/auth_pkg.sv
package auth_pkg;

  localparam int unsigned CHAL_BYTES = 8;
  localparam int unsigned W0_SLOTS   = 8;
  localparam int unsigned MAC_BITS   = 160;
  localparam int unsigned RF_AW      = 5;
  localparam int unsigned STEP_W     = 8;

  localparam logic [7:0] BYTE_SKIP = 8'hCC;
  localparam logic [7:0] BYTE_WCH  = 8'h0C;
  localparam logic [7:0] BYTE_MAC  = 8'h36;

  localparam int unsigned ST_RST1  = 0;
  localparam int unsigned ST_SKIP1 = 1;
  localparam int unsigned ST_WCH   = 2;
  localparam int unsigned ST_CHAL0 = 3;
  localparam int unsigned ST_RST2  = ST_CHAL0 + CHAL_BYTES;
  localparam int unsigned ST_SKIP2 = ST_RST2 + 1;
  localparam int unsigned ST_MAC   = ST_SKIP2 + 1;
  localparam int unsigned ST_W0    = ST_MAC + 1;
  localparam int unsigned ST_RD0   = ST_W0 + W0_SLOTS;
  localparam int unsigned ST_FINAL = ST_RD0 + MAC_BITS;

  typedef enum logic [1:0] {
    OP_RESET = 2'd0,
    OP_WBYTE = 2'd1,
    OP_WR0   = 2'd2,
    OP_RDBIT = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    RES_NONE = 2'd0,
    RES_NP   = 2'd1,
    RES_PASS = 2'd2,
    RES_FAIL = 2'd3
  } res_e;

  function automatic op_e step_op(input logic [STEP_W-1:0] s);
    if (s == STEP_W'(ST_RST1) || s == STEP_W'(ST_RST2) || s == STEP_W'(ST_FINAL))
      return OP_RESET;
    else if (s >= STEP_W'(ST_RD0))
      return OP_RDBIT;
    else if (s >= STEP_W'(ST_W0))
      return OP_WR0;
    else
      return OP_WBYTE;
  endfunction

  function automatic logic [7:0] step_byte(input logic [STEP_W-1:0] s,
                                           input logic [7:0] rf);
    if (s == STEP_W'(ST_SKIP1) || s == STEP_W'(ST_SKIP2)) return BYTE_SKIP;
    else if (s == STEP_W'(ST_WCH)) return BYTE_WCH;
    else if (s == STEP_W'(ST_MAC)) return BYTE_MAC;
    else return rf;
  endfunction

  // Challenge steps map to bytes 0..7, read slots to the response area.
  function automatic logic [RF_AW-1:0] step_rf_addr(input logic [STEP_W-1:0] s);
    logic [STEP_W-1:0] k;
    if (s >= STEP_W'(ST_CHAL0) && s < STEP_W'(ST_RST2))
      return RF_AW'(s - STEP_W'(ST_CHAL0));
    else if (s >= STEP_W'(ST_RD0) && s < STEP_W'(ST_FINAL)) begin
      k = s - STEP_W'(ST_RD0);
      return RF_AW'(CHAL_BYTES) + RF_AW'(k >> 3);
    end else
      return '0;
  endfunction

  function automatic logic [2:0] step_bit_idx(input logic [STEP_W-1:0] s);
    logic [STEP_W-1:0] k;
    k = s - STEP_W'(ST_RD0);
    return k[2:0];
  endfunction

  function automatic logic [3:0] attempts_of(input logic [1:0] sel);
    return 4'd1 << sel;
  endfunction

endpackage

// File: rtl/auth_spu_timer.sv
module auth_spu_timer #(
  parameter int unsigned HOLD = 8_500_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic active,
  output logic expire
);
  localparam int unsigned CW = $clog2(HOLD + 1);

  logic [CW-1:0] cnt_q;
  logic          act_q;

  assign active = act_q;
  assign expire = act_q && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (load) begin
      cnt_q <= CW'(HOLD - 1);
      act_q <= 1'b1;
    end else if (act_q) begin
      if (cnt_q == '0) act_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/auth_mac_cmp.sv
module auth_mac_cmp (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic bit_valid,
  input  logic rx_bit,
  input  logic ref_bit,
  output logic bit_err,
  output logic mismatch
);
  logic mis_q;

  assign bit_err  = bit_valid && (rx_bit != ref_bit);
  assign mismatch = mis_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     mis_q <= 1'b0;
    else if (clear) mis_q <= 1'b0;
    else if (bit_err) mis_q <= 1'b1;
  end
endmodule

// File: rtl/auth_attempt_ctr.sv
module auth_attempt_ctr import auth_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [1:0] sel,
  input  logic       inc,
  output logic       last
);
  logic [3:0] att_q;
  logic [3:0] lim_q;

  assign last = (att_q + 4'd1) == lim_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      att_q <= '0;
      lim_q <= 4'd1;
    end else if (load) begin
      att_q <= '0;
      lim_q <= attempts_of(sel);
    end else if (inc) begin
      att_q <= att_q + 4'd1;
    end
  end
endmodule

// File: rtl/auth_seq.sv
module auth_seq import auth_pkg::*; #(
  parameter int unsigned SPU_HOLD_CYCLES = 8_500_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       retry_sel,
  output logic             ow_req,
  output logic [1:0]       ow_op,
  output logic [7:0]       ow_wdata,
  input  logic             ow_done,
  input  logic             ow_presence,
  input  logic             ow_rbit,
  output logic [RF_AW-1:0] rf_addr,
  input  logic [7:0]       rf_data,
  output logic             spu_en,
  output logic             busy,
  output logic             done,
  output logic [1:0]       result
);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_SPU} st_e;

  st_e               state_q;
  logic [STEP_W-1:0] step_q;
  logic              done_q;
  logic [1:0]        res_q;

  // Named internal events
  op_e  cur_op;
  logic ev_accept;
  logic ev_op_done;
  logic ev_no_pres;
  logic ev_final;
  logic ev_rd_bit;
  logic ev_retry;
  logic ev_spu_go;
  logic ev_finish;
  logic ref_bit;
  logic bit_err;
  logic mismatch;
  logic last_att;
  logic spu_expire;

  assign cur_op     = step_op(step_q);
  assign ev_accept  = (state_q == S_IDLE) && start;
  assign ev_op_done = (state_q == S_WAIT) && ow_done;
  assign ev_no_pres = ev_op_done && (cur_op == OP_RESET) && !ow_presence;
  assign ev_final   = ev_op_done && !ev_no_pres && (step_q == STEP_W'(ST_FINAL));
  assign ev_rd_bit  = ev_op_done && (cur_op == OP_RDBIT);
  assign ev_retry   = ev_final && mismatch && !last_att;
  assign ev_spu_go  = ev_op_done && (step_q == STEP_W'(ST_MAC));
  assign ev_finish  = ev_no_pres || (ev_final && !ev_retry);

  assign rf_addr  = step_rf_addr(step_q);
  assign ref_bit  = rf_data[step_bit_idx(step_q)];
  assign ow_req   = (state_q == S_ISSUE);
  assign ow_op    = cur_op;
  assign ow_wdata = step_byte(step_q, rf_data);
  assign busy     = (state_q != S_IDLE);
  assign done     = done_q;
  assign result   = res_q;

  auth_spu_timer #(.HOLD(SPU_HOLD_CYCLES)) u_spu (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (ev_spu_go),
    .active (spu_en),
    .expire (spu_expire)
  );

  auth_mac_cmp u_cmp (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (ev_accept || ev_retry),
    .bit_valid (ev_rd_bit),
    .rx_bit    (ow_rbit),
    .ref_bit   (ref_bit),
    .bit_err   (bit_err),
    .mismatch  (mismatch)
  );

  auth_attempt_ctr u_att (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (ev_accept),
    .sel   (retry_sel),
    .inc   (ev_retry),
    .last  (last_att)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      step_q  <= '0;
      done_q  <= 1'b0;
      res_q   <= RES_NONE;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (start) begin
            step_q  <= '0;
            state_q <= S_ISSUE;
          end
        end
        S_ISSUE: state_q <= S_WAIT;
        S_WAIT: begin
          if (ow_done) begin
            if (ev_finish) begin
              state_q <= S_IDLE;
              done_q  <= 1'b1;
              if (ev_no_pres)    res_q <= RES_NP;
              else if (mismatch) res_q <= RES_FAIL;
              else               res_q <= RES_PASS;
            end else if (ev_retry) begin
              step_q  <= '0;
              state_q <= S_ISSUE;
            end else if (ev_spu_go) begin
              state_q <= S_SPU;
            end else begin
              step_q  <= step_q + 1'b1;
              state_q <= S_ISSUE;
            end
          end
        end
        S_SPU: begin
          if (spu_expire) begin
            step_q  <= step_q + 1'b1;
            state_q <= S_ISSUE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/auth_seq_chk.sv
module auth_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ow_req,
  input logic [1:0] ow_op,
  input logic       spu_en,
  input logic       busy,
  input logic       done,
  input logic [1:0] result
);

  // R6: no bus request while the strong pull-up is on
  p_req_not_spu_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ow_req |-> !spu_en);

  // R6: release of the pull-up coincides with the first write-0 request
  p_spu_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spu_en) |-> (ow_req && ow_op == 2'd2));

  // R3: a request lasts one cycle, then the block waits
  p_req_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ow_req |=> !ow_req);

  // R10: done is a single-cycle pulse
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: a completion always carries a defined code
  p_done_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result != 2'd0));

  // R10: result changes only together with done
  p_result_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));

  // R9: the run ends only through a completion
  p_end_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R1: requests only occur inside a run
  p_req_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ow_req |-> busy);

endmodule

bind auth_seq auth_seq_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .ow_req (ow_req),
  .ow_op  (ow_op),
  .spu_en (spu_en),
  .busy   (busy),
  .done   (done),
  .result (result)
);

// File: tb/auth_seq_test.sv
`timescale 1ns/1ps
module auth_seq_test;

  localparam int SPU = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [1:0] retry_sel = 2'd0;
  logic       ow_req;
  logic [1:0] ow_op;
  logic [7:0] ow_wdata;
  logic       ow_done = 1'b0;
  logic       ow_presence = 1'b0;
  logic       ow_rbit = 1'b0;
  logic [4:0] rf_addr;
  logic [7:0] rf_data;
  logic       spu_en;
  logic       busy;
  logic       done;
  logic [1:0] result;

  always #2 clk = ~clk;

  auth_seq #(.SPU_HOLD_CYCLES(SPU)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .retry_sel(retry_sel),
    .ow_req(ow_req), .ow_op(ow_op), .ow_wdata(ow_wdata),
    .ow_done(ow_done), .ow_presence(ow_presence), .ow_rbit(ow_rbit),
    .rf_addr(rf_addr), .rf_data(rf_data), .spu_en(spu_en),
    .busy(busy), .done(done), .result(result)
  );

  // Stored challenge and response, computed
  function automatic logic [7:0] chal_b(input int i);
    return 8'(i * 17 + 8'h5A);
  endfunction
  function automatic logic [7:0] mac_b(input int j);
    return 8'(j * 53) ^ 8'h96;
  endfunction
  function automatic logic mac_bit(input int k);
    logic [7:0] b;
    b = mac_b(k / 8);
    return b[k % 8];
  endfunction

  assign rf_data = (rf_addr < 5'd8) ? chal_b(int'(rf_addr)) : mac_b(int'(rf_addr) - 8);

  int checks = 0;
  int errors = 0;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Token model controls and observations
  int bad_att = 0, bad_bit = 0, np_at = 0;
  int n_reset = 0, n_wb = 0, n_w0 = 0, n_rd = 0, n36 = 0;
  int spu_cyc = 0, done_cnt = 0;
  logic [7:0] blog [0:15];

  initial begin : engine
    @(posedge clk); #1;
    forever begin
      if (!ow_req) begin
        @(posedge clk); #1;
      end else begin
        logic pres;
        logic rb;
        pres = 1'b1;
        rb = 1'b0;
        case (ow_op)
          2'd0: begin n_reset++; pres = (n_reset != np_at); end
          2'd1: begin
            if (n_wb < 16) blog[n_wb] = ow_wdata;
            n_wb++;
            if (ow_wdata == 8'h36) n36++;
          end
          2'd2: n_w0++;
          default: begin
            int k;
            k = n_rd % 160;
            rb = mac_bit(k) ^ (((n36 - 1) < bad_att) && (k == bad_bit));
            n_rd++;
          end
        endcase
        repeat (2) @(posedge clk);
        #1 ow_done = 1'b1; ow_presence = pres; ow_rbit = rb;
        @(posedge clk);
        #1 ow_done = 1'b0;
      end
    end
  end

  initial begin : monitor
    forever begin
      @(posedge clk); #1;
      if (spu_en) spu_cyc++;
      if (done) done_cnt++;
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  // columns: retry_sel, bad attempts, bad bit, no-presence reset index, result, resets
  localparam int NV = 11;
  localparam int VEC [NV][6] = '{
    '{0, 0,   0, 0, 2,  3},
    '{0, 1,   0, 0, 3,  3},
    '{1, 1, 159, 0, 2,  6},
    '{2, 4,  77, 0, 3, 12},
    '{3, 3,   8, 0, 2, 12},
    '{3, 8,   1, 0, 3, 24},
    '{0, 0,   0, 1, 1,  1},
    '{1, 0,   0, 2, 1,  2},
    '{1, 1,   5, 3, 1,  3},
    '{2, 1,  40, 4, 1,  4},
    '{1, 2, 100, 0, 3,  6}
  };

  task automatic run_vec(input int sel, input int bad, input int bbit, input int np,
                         input int exp_res, input int exp_resets, input bit poke);
    int t;
    int res_seen;
    bad_att = bad; bad_bit = bbit; np_at = np;
    n_reset = 0; n_wb = 0; n_w0 = 0; n_rd = 0; n36 = 0; spu_cyc = 0; done_cnt = 0;
    @(posedge clk); #1 retry_sel = 2'(sel); start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    if (poke) begin
      repeat (300) @(posedge clk);
      #1 retry_sel = 2'd3; start = 1'b1;
      @(posedge clk); #1 start = 1'b0; retry_sel = 2'(sel);
    end
    t = 0;
    while (!done && t < 20000) begin @(posedge clk); #1; t++; end
    res_seen = int'(result);
    check("R10 result code", res_seen, exp_res);
    check("R7 R9 reset count", n_reset, exp_resets);
    repeat (6) @(posedge clk); #1;
    check("R10 single done", done_cnt, 1);
    check("R10 result held", int'(result), res_seen);
    check("R9 idle after run", int'(busy), 0);
    check("R4 read slots", n_rd, 160 * n36);
    check("R3 write-0 slots", n_w0, 8 * n36);
    check("R6 pullup cycles", spu_cyc, SPU * n36);
    if (exp_resets >= 3) begin
      check("R2 skip byte", int'(blog[0]), 8'hCC);
      check("R2 challenge cmd", int'(blog[1]), 8'h0C);
      for (int i = 0; i < 8; i++)
        check("R2 challenge byte", int'(blog[2 + i]), int'(chal_b(i)));
      check("R3 second skip", int'(blog[10]), 8'hCC);
      check("R3 compute cmd", int'(blog[11]), 8'h36);
    end
  endtask

  initial begin : stim
    repeat (3) @(posedge clk); #1;
    check("R1 busy in reset", int'(busy), 0);
    check("R1 done in reset", int'(done), 0);
    check("R1 req in reset", int'(ow_req), 0);
    check("R1 spu in reset", int'(spu_en), 0);
    check("R1 result in reset", int'(result), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 idle after reset", int'(busy), 0);

    // R5 R7 R8 R9: table walk
    for (int v = 0; v < NV; v++)
      run_vec(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5], 1'b0);

    // R11: start during a single-attempt failing run must not add attempts
    run_vec(0, 8, 3, 0, 3, 3, 1'b1);
    // R11: start during a passing run
    run_vec(1, 0, 0, 0, 2, 3, 1'b1);
    // R5: mismatch in the very last bit with one attempt
    run_vec(0, 1, 159, 0, 3, 3, 1'b0);

    finish_run();
  end

endmodule